// File: doc/BRIEF.md
# Emulation Float Isolation Control

This block lets an external emulator take over a board by electrically isolating the core's bus. It watches an asynchronous, active-low float request. Once the request has been recognised on a rising edge of the fast clock, the block floats every output and bidirectional bus pin, including the hold-acknowledge pin. It also sends a one-cycle abort strobe to the bus sequencer so that any bus cycle in progress is dropped.

Float is unconditional. It takes priority over hold acknowledge and over reset. Leaving float puts the core in a known state only when reset is already asserted before the request is released. For this reason the block keeps a sticky flag that says a reset is still owed. While that flag is set, no new bus cycle may start.

Top module: `emu_float_ctrl`

## Requirements
- R1: When reset is held with the float request high (inactive) for at least SYNC_STAGES cycles, float_all=0, abort_cycle=0, bus_oe=1 and hlda_oe=1. need_reset reads 0 one cycle after reset is applied.
- R2: Recognition latency. A low level on float_req_n that is present at a rising edge shows on float_all=1 after SYNC_STAGES rising edges (2 by default), and not before.
- R3: abort_cycle is 1 for exactly one cycle. That cycle is the first cycle in which float_all is 1 after being 0. It does not depend on hold_ack or start_req.
- R4: While float_all=1, both bus_oe and hlda_oe are 0, whatever the value of hold_ack.
- R5: While float_all=0, bus_oe equals the inverse of hold_ack and hlda_oe is 1.
- R6: need_reset becomes 1 one cycle after float_all becomes 1. It stays 1 after the request is released unless rst is sampled high while float_all is 0.
- R7: Valid exit. If rst is sampled high while float_all=0, need_reset reads 0 on the next cycle. This is the case when reset is asserted before the release and held until float_all has dropped.
- R8: start_ok equals start_req only when rst=0, float_all=0 and need_reset=0. Otherwise it is 0.
- R9: Reset does not cancel float. A float request that arrives while rst is high still gives float_all=1 and need_reset=1.
- R10: After float_req_n returns high, float_all returns to 0 after SYNC_STAGES rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Core reset, active high, synchronous |
| float_req_n | input | 1 | Asynchronous float request, active low |
| hold_ack | input | 1 | Hold-acknowledge state from the bus arbiter |
| start_req | input | 1 | Bus sequencer asks to begin a cycle |
| float_all | output | 1 | All bus outputs tri-stated |
| abort_cycle | output | 1 | One-cycle abort strobe to the bus sequencer |
| need_reset | output | 1 | A reset is still owed after a float episode |
| bus_oe | output | 1 | Output enable for address, data and control pins |
| hlda_oe | output | 1 | Output enable for the hold-acknowledge pin |
| start_ok | output | 1 | Permission for the requested bus cycle to start |

## Verification
A stale synchroniser stage shows up as a recognition or release edge that is one cycle early or late on float_all. The outputs bus_oe and hlda_oe show the same error in that same cycle. A wrong entry-detect register gives an abort strobe that is missing, doubled or stretched, and this is visible within one cycle of entry. An error in the sticky reset flag shows up as start_ok rising after a float episode that ended without reset, or as start_ok staying low after a correct reset exit. In both cases the error is visible on the first cycle after release or after reset.

// File: rtl/emu_float_ctrl.sv
module emu_float_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic float_req_n,
  input  logic hold_ack,
  input  logic start_req,
  output logic float_all,
  output logic abort_cycle,
  output logic need_reset,
  output logic bus_oe,
  output logic hlda_oe,
  output logic start_ok
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   float_d;

  // free-running synchroniser: float must be seen even while reset is held
  always_ff @(posedge clk) begin
    sync_q <= {sync_q[SYNC_STAGES-2:0], float_req_n};
    float_d <= float_all;
  end

  assign float_all   = ~sync_q[SYNC_STAGES-1];
  assign abort_cycle = float_all & ~float_d;

  always_ff @(posedge clk) begin
    if (float_all)
      need_reset <= 1'b1;
    else if (rst)
      need_reset <= 1'b0;
  end

  assign bus_oe   = ~float_all & ~hold_ack;
  assign hlda_oe  = ~float_all;
  assign start_ok = start_req & ~rst & ~float_all & ~need_reset;

endmodule

// File: rtl/emu_float_ctrl_chk.sv
module emu_float_ctrl_chk #(
  parameter int MIN_LOW = 16
) (
  input logic clk,
  input logic rst,
  input logic float_all,
  input logic abort_cycle,
  input logic need_reset,
  input logic bus_oe,
  input logic hlda_oe,
  input logic start_ok
);
  localparam int CW = $clog2(MIN_LOW + 1) + 1;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!float_all)
      low_cnt <= '0;
    else if (low_cnt < CW'(MIN_LOW))
      low_cnt <= low_cnt + 1'b1;
  end

  p_abort_on_entry_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(float_all) |-> abort_cycle);
  p_abort_single_r3: assert property (@(posedge clk) disable iff (rst)
    abort_cycle |=> !abort_cycle);
  p_float_isolates_r4: assert property (@(posedge clk) disable iff (rst)
    float_all |-> (!bus_oe && !hlda_oe));
  p_sticky_flag_r6: assert property (@(posedge clk) disable iff (rst)
    need_reset |=> (need_reset || $past(rst)));
  p_flag_after_float_r6: assert property (@(posedge clk) disable iff (rst)
    float_all |=> need_reset);
  p_no_start_r8: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> (!need_reset && !float_all));
  // protocol: request must have been held for the minimum width
  p_min_width_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(float_all) |-> (low_cnt >= CW'(MIN_LOW)));
endmodule

bind emu_float_ctrl emu_float_ctrl_chk #(.MIN_LOW(16)) chk_i (
  .clk(clk), .rst(rst), .float_all(float_all), .abort_cycle(abort_cycle),
  .need_reset(need_reset), .bus_oe(bus_oe), .hlda_oe(hlda_oe),
  .start_ok(start_ok)
);

// File: tb/emu_float_ctrl_tb.sv
module emu_float_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic float_req_n = 1'b1;
  logic hold_ack = 1'b0;
  logic start_req = 1'b0;
  logic float_all, abort_cycle, need_reset, bus_oe, hlda_oe, start_ok;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emu_float_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .float_req_n(float_req_n), .hold_ack(hold_ack),
    .start_req(start_req), .float_all(float_all), .abort_cycle(abort_cycle),
    .need_reset(need_reset), .bus_oe(bus_oe), .hlda_oe(hlda_oe),
    .start_ok(start_ok)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset_state;
    rst = 1'b1; float_req_n = 1'b1; hold_ack = 1'b0; start_req = 1'b1;
    step(4);
    chk("R1 float_all", float_all, 1'b0);
    chk("R1 abort", abort_cycle, 1'b0);
    chk("R1 need_reset", need_reset, 1'b0);
    chk("R1 bus_oe", bus_oe, 1'b1);
    chk("R1 hlda_oe", hlda_oe, 1'b1);
    chk("R8 start_ok in reset", start_ok, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R8 start_ok free", start_ok, 1'b1);
    start_req = 1'b0;
    step(1);
    chk("R8 start_ok follows req", start_ok, 1'b0);
  endtask

  task automatic t_hold_only;
    hold_ack = 1'b1;
    step(1);
    chk("R5 bus_oe in hold", bus_oe, 1'b0);
    chk("R5 hlda_oe in hold", hlda_oe, 1'b1);
    hold_ack = 1'b0;
    step(1);
    chk("R5 bus_oe no hold", bus_oe, 1'b1);
  endtask

  // entry, then release without reset: flag must stay
  task automatic t_float_no_reset;
    hold_ack = 1'b1; start_req = 1'b1;
    float_req_n = 1'b0;
    step(SYNC - 1);
    chk("R2 not yet floating", float_all, 1'b0);
    chk("R3 no early abort", abort_cycle, 1'b0);
    step(1);
    chk("R2 floating", float_all, 1'b1);
    chk("R3 abort strobe", abort_cycle, 1'b1);
    chk("R4 bus_oe off", bus_oe, 1'b0);
    chk("R4 hlda_oe off over hold", hlda_oe, 1'b0);
    chk("R8 no start in float", start_ok, 1'b0);
    step(1);
    chk("R3 abort single", abort_cycle, 1'b0);
    chk("R6 need_reset set", need_reset, 1'b1);
    step(18);
    float_req_n = 1'b1;
    step(SYNC - 1);
    chk("R10 still floating", float_all, 1'b1);
    step(1);
    chk("R10 released", float_all, 1'b0);
    chk("R4 hlda back", hlda_oe, 1'b1);
    step(5);
    chk("R6 flag sticky", need_reset, 1'b1);
    chk("R8 start blocked by flag", start_ok, 1'b0);
    hold_ack = 1'b0;
    rst = 1'b1;
    step(1);
    chk("R7 cleared by reset", need_reset, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R8 start after reset", start_ok, 1'b1);
  endtask

  // valid exit: reset before release
  task automatic t_valid_exit;
    start_req = 1'b1; hold_ack = 1'b0;
    float_req_n = 1'b0;
    step(SYNC);
    chk("R3 abort without hold", abort_cycle, 1'b1);
    step(20);
    rst = 1'b1;
    step(2);
    chk("R9 reset keeps float", float_all, 1'b1);
    chk("R9 flag held in reset", need_reset, 1'b1);
    float_req_n = 1'b1;
    step(SYNC);
    chk("R10 release in reset", float_all, 1'b0);
    step(1);
    chk("R7 flag cleared", need_reset, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R8 start after valid exit", start_ok, 1'b1);
    start_req = 1'b0;
  endtask

  // request arrives while reset held
  task automatic t_float_in_reset;
    rst = 1'b1;
    step(2);
    float_req_n = 1'b0;
    step(SYNC);
    chk("R9 float in reset", float_all, 1'b1);
    chk("R9 bus off in reset", bus_oe, 1'b0);
    step(1);
    chk("R9 flag in reset", need_reset, 1'b1);
    step(17);
    float_req_n = 1'b1;
    step(SYNC + 1);
    chk("R7 exit in reset", need_reset, 1'b0);
    rst = 1'b0;
    step(1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_hold_only();
        t_float_no_reset();
        t_valid_exit();
        t_float_in_reset();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule